// File: doc/BRIEF.md
# DDR Read/Write Command Spacing Guard

This block sits between a command generator and the command bus of a double-data-rate mobile SDRAM. It holds back commands that would break the data-bus timing of earlier reads. The generator presents at most one request per clock: READ, WRITE, burst-terminate or NOP. The guard decides in the same cycle whether to grant or stall it. A stalled request must be held until it is granted. Every granted command, with its bank and column fields, is registered onto the memory command bus one clock later. A NOP is driven on the bus in every cycle where nothing was granted.

Two spacing rules are enforced.

The first rule sets the earliest WRITE after a READ. The gap is the read latency, plus a precomputed round-up of the output skew divided by the clock period, plus half the burst length, plus one, minus the write latency. A burst-terminate that cuts a READ short recomputes this gap from the shortened burst.

The second rule sets the spacing between READs. A new READ may start only once the previous burst has left the data bus, which is half the burst length in clocks. This spacing still allows seamless back-to-back reads.

Read latency, write latency, burst length and the skew term are runtime configuration inputs. Each stall carries a code naming the rule that caused it.

Top module: `ddr_cmd_spacer`

## Requirements
- R1: After synchronous reset the command bus carries NOP (code 0) and no stall is raised. The first READ and the first WRITE after reset are granted in the cycle they are presented.
- R2: Let a READ be granted in cycle t, with G = RL + SKEW + BL/2 + 1 − WL. A WRITE is stalled in every cycle before t+G and granted in the first cycle at or after t+G in which it is presented. If G < 1, a WRITE is allowed from t+1.
- R3: Let a READ be granted in cycle t. A later READ is stalled before t+BL/2 and granted from t+BL/2 on. The burst length code on cfg_bl is 0 for BL=4, 1 for BL=8, and 2 or 3 for BL=16, giving spacings of 2, 4 and 8.
- R4: A burst-terminate granted k clocks after the last READ, with k < BL/2, reloads the WRITE gap with BL replaced by min(2k, BL). A WRITE is then allowed from READ cycle + RL + SKEW + k + 1 − WL, and never before the cycle after the terminate.
- R5: A burst-terminate granted k ≥ BL/2 clocks after the last READ, or with no READ since reset, leaves the WRITE gap unchanged.
- R6: A command granted in cycle t appears on bus_cmd, bus_bank and bus_col in cycle t+1. A cycle with no grant puts NOP on bus_cmd in the next cycle.
- R7: NOP and burst-terminate requests are always granted. The command codes are 0 NOP, 1 READ, 2 WRITE and 3 burst-terminate.
- R8: stall_cause is 1 when a WRITE is held by the READ-to-WRITE rule, 2 when a READ is held by the READ-to-READ rule, and 0 in every cycle without a stall. A presented request is either granted or stalled, never both.
- R9: A granted WRITE does not delay a following READ: a READ presented in the next cycle is granted if the READ spacing allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_cmd | input | 2 | Requested command code |
| req_bank | input | 3 | Bank field of the request |
| req_col | input | 10 | Column field of the request |
| cfg_rl | input | 4 | Read latency in clocks |
| cfg_wl | input | 4 | Write latency in clocks |
| cfg_bl | input | 2 | Burst length code |
| cfg_skew | input | 3 | Rounded-up output skew in clocks |
| req_grant | output | 1 | Request accepted this cycle |
| stall | output | 1 | Request held this cycle |
| stall_cause | output | 2 | Rule responsible for the stall |
| bus_cmd | output | 2 | Registered command on the memory bus |
| bus_bank | output | 3 | Registered bank field |
| bus_col | output | 10 | Registered column field |

## Verification
The test patterns are chosen so that each one tells apart a different way the guard could be wrong.

- A READ followed by a held WRITE, with RL=3, WL=1, BL=4 and skew 1, must give a grant exactly six clocks later. This rejects an off-by-one gap and any formula that drops a term.
- Back-to-back READs at each burst-length code show whether the read spacing follows the programmed burst length.
- A terminate placed inside a burst must shorten the write gap. The same terminate placed after the burst has ended must leave the gap untouched. Together these two cases separate a correct rule from one that applies the shortening in both cases or in neither.
- A WRITE followed at once by a READ shows that writes do not load the read counter.

// File: rtl/ddr_spc_pkg.sv
package ddr_spc_pkg;

    localparam int LAT_W  = 4;
    localparam int SKEW_W = 3;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_BST = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_RD2WR = 2'd1,
        CAUSE_RD2RD = 2'd2
    } cause_e;

    typedef struct packed {
        logic [LAT_W-1:0]  rl;
        logic [LAT_W-1:0]  wl;
        logic [1:0]        bl_code;
        logic [SKEW_W-1:0] skew;
    } cfg_t;

    // Clocks of data-bus occupancy per burst (BL/2).
    function automatic logic [CNT_W-1:0] burst_clocks(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(2);
            2'd1:    return CNT_W'(4);
            default: return CNT_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/spc_downcnt.sv
module spc_downcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

    // R2: a counter at zero stays at zero without a load
    p_zero_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);
endmodule

// File: rtl/spc_gap_calc.sv
module spc_gap_calc
    import ddr_spc_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] since_rd,
    output logic [CNT_W-1:0] half_bl,
    output logic [CNT_W-1:0] rd_load,
    output logic [CNT_W-1:0] bst_load,
    output logic [CNT_W-1:0] rr_load
);
    localparam int SW = CNT_W + 2;

    logic [SW-1:0] base, pos_rd, neg_rd, pos_bst, neg_bst, eff_half;

    always_comb begin
        half_bl  = burst_clocks(cfg.bl_code);
        base     = SW'(cfg.rl) + SW'(cfg.skew) + SW'(1);
        eff_half = (since_rd < half_bl) ? SW'(since_rd) : SW'(half_bl);
        pos_rd   = base + SW'(half_bl);
        neg_rd   = SW'(cfg.wl);
        pos_bst  = base + eff_half;
        neg_bst  = SW'(cfg.wl) + SW'(since_rd);
        // Counter value after the load edge is the remaining gap minus one.
        rd_load  = (pos_rd  > neg_rd)  ? CNT_W'(pos_rd  - neg_rd  - SW'(1)) : '0;
        bst_load = (pos_bst > neg_bst) ? CNT_W'(pos_bst - neg_bst - SW'(1)) : '0;
        rr_load  = half_bl - CNT_W'(1);
    end
endmodule

// File: rtl/ddr_cmd_spacer.sv
module ddr_cmd_spacer
    import ddr_spc_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LAT_W-1:0]  cfg_rl,
    input  logic [LAT_W-1:0]  cfg_wl,
    input  logic [1:0]        cfg_bl,
    input  logic [SKEW_W-1:0] cfg_skew,
    output logic              req_grant,
    output logic              stall,
    output logic [1:0]        stall_cause,
    output logic [1:0]        bus_cmd,
    output logic [BANK_W-1:0] bus_bank,
    output logic [COL_W-1:0]  bus_col
);
    localparam logic [CNT_W-1:0] SINCE_MAX = '1;

    cfg_t             cfg;
    cmd_e             req_c;
    cause_e           cause;
    logic [CNT_W-1:0] since_q, half_bl, rd_load, bst_load, rr_load;
    logic             r2w_zero, r2r_zero, blk_w, blk_r;
    logic             rd_go, bst_go, rd_active;

    assign cfg   = '{rl: cfg_rl, wl: cfg_wl, bl_code: cfg_bl, skew: cfg_skew};
    assign req_c = cmd_e'(req_cmd);

    spc_gap_calc u_calc (
        .cfg      (cfg),
        .since_rd (since_q),
        .half_bl  (half_bl),
        .rd_load  (rd_load),
        .bst_load (bst_load),
        .rr_load  (rr_load)
    );

    always_comb begin
        blk_w     = (req_c == CMD_WR) && !r2w_zero;
        blk_r     = (req_c == CMD_RD) && !r2r_zero;
        stall     = req_valid && (blk_w || blk_r);
        req_grant = req_valid && !(blk_w || blk_r);
        if (!stall)     cause = CAUSE_NONE;
        else if (blk_w) cause = CAUSE_RD2WR;
        else            cause = CAUSE_RD2RD;
        rd_active = (since_q < half_bl);
        rd_go     = req_grant && (req_c == CMD_RD);
        bst_go    = req_grant && (req_c == CMD_BST) && rd_active;
    end
    assign stall_cause = cause;

    spc_downcnt #(.W(CNT_W)) u_r2w (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_go || bst_go),
        .load_val (rd_go ? rd_load : bst_load),
        .zero     (r2w_zero)
    );

    spc_downcnt #(.W(CNT_W)) u_r2r (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_go),
        .load_val (rr_load),
        .zero     (r2r_zero)
    );

    // Clocks elapsed since the last granted READ, saturating.
    always_ff @(posedge clk) begin
        if (rst)
            since_q <= SINCE_MAX;
        else if (rd_go)
            since_q <= CNT_W'(1);
        else if (since_q != SINCE_MAX)
            since_q <= since_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_cmd  <= CMD_NOP;
            bus_bank <= '0;
            bus_col  <= '0;
        end else begin
            bus_cmd  <= req_grant ? req_cmd : CMD_NOP;
            bus_bank <= req_bank;
            bus_col  <= req_col;
        end
    end

    // R6: a stall leaves NOP on the bus next cycle
    p_stall_nop_r6: assert property (@(posedge clk) disable iff (rst)
        stall |=> (bus_cmd == CMD_NOP));
    // R6: granted command reaches the bus one clock later
    p_bus_follows_r6: assert property (@(posedge clk) disable iff (rst)
        req_grant |=> (bus_cmd == $past(req_cmd)));
    // R7: terminate is never held
    p_bst_granted_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_cmd == CMD_BST) |-> req_grant);
    // R8: no cause code without a stall
    p_cause_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !stall |-> (stall_cause == CAUSE_NONE));
    // R3: two READs are never granted in consecutive cycles
    p_rr_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (req_grant && req_cmd == CMD_RD) |=> !(req_grant && req_cmd == CMD_RD));
endmodule

// File: tb/ddr_cmd_spacer_tb.sv
module ddr_cmd_spacer_tb;
    localparam int NOP = 0, RD = 1, WR = 2, BST = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_cmd = 2'd0;
    logic [2:0] req_bank = 3'd0;
    logic [9:0] req_col = 10'd0;
    logic [3:0] cfg_rl = 4'd3, cfg_wl = 4'd1;
    logic [1:0] cfg_bl = 2'd0;
    logic [2:0] cfg_skew = 3'd1;
    logic       req_grant, stall;
    logic [1:0] stall_cause, bus_cmd;
    logic [2:0] bus_bank;
    logic [9:0] bus_col;

    int errors = 0, checks = 0;
    int cyc = 0, last_rd = -1000, wr_ok = 0, rd_ok = 0;
    int exp_bus = 0, exp_bank = 0, exp_col = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ddr_cmd_spacer u_dut (.*);

    function automatic int half_of(input int code);
        return code == 0 ? 2 : (code == 1 ? 4 : 8);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One clock: drive, compare with the model, advance the model.
    task automatic step(input bit v, input int c, input int bank, input int col,
                        output bit granted);
        int half, gap, exp_stall, exp_cause, k;
        @(negedge clk);
        req_valid = v; req_cmd = 2'(c); req_bank = 3'(bank); req_col = 10'(col);
        #2;
        half = half_of(cfg_bl);
        exp_stall = 0; exp_cause = 0;
        if (v && c == WR && cyc < wr_ok) begin exp_stall = 1; exp_cause = 1; end
        if (v && c == RD && cyc < rd_ok) begin exp_stall = 1; exp_cause = 2; end
        check("R2/R3 stall", stall, exp_stall);
        check("R8 cause", stall_cause, exp_cause);
        check("R7/R8 grant", req_grant, v && !exp_stall);
        check("R6 bus_cmd", bus_cmd, exp_bus);
        if (exp_bus != NOP) begin
            check("R6 bus_bank", bus_bank, exp_bank);
            check("R6 bus_col", bus_col, exp_col);
        end
        granted = v && !exp_stall;
        if (granted && c == RD) begin
            gap = cfg_rl + cfg_skew + half + 1 - cfg_wl;
            wr_ok = cyc + (gap < 1 ? 1 : gap);
            rd_ok = cyc + half;
            last_rd = cyc;
        end
        if (granted && c == BST) begin
            k = cyc - last_rd;
            if (k < half) wr_ok = last_rd + cfg_rl + cfg_skew + k + 1 - cfg_wl;
        end
        exp_bus = granted ? c : NOP; exp_bank = bank; exp_col = col;
        cyc++;
    endtask

    task automatic idle(input int n);
        bit g;
        for (int i = 0; i < n; i++) step(0, NOP, 0, 0, g);
    endtask

    // Hold a request until granted; returns the grant cycle.
    task automatic issue(input int c, input int bank, input int col, output int at);
        bit g = 0;
        while (!g) begin
            at = cyc;
            step(1, c, bank, col, g);
        end
    endtask

    initial begin
        int t_rd, t_x;
        bit g;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        #2;
        check("R1 bus NOP", bus_cmd, NOP);
        check("R1 no stall", stall, 0);
        issue(WR, 1, 5, t_x);
        check("R1 first WRITE immediate", t_x, 0);
        issue(RD, 2, 7, t_rd);
        check("R1 first READ immediate", t_rd, 1);
        idle(12);

        // R2: RL=3 WL=1 BL=4 skew=1 -> WRITE 6 clocks after READ
        issue(RD, 3, 100, t_rd);
        issue(WR, 3, 104, t_x);
        check("R2 READ-to-WRITE gap", t_x - t_rd, 6);
        idle(12);

        // R3: READ spacing for each burst length
        for (int code = 0; code < 3; code++) begin
            cfg_bl = 2'(code);
            idle(4);
            issue(RD, 0, 8, t_rd);
            issue(RD, 0, 16, t_x);
            check("R3 READ-to-READ spacing", t_x - t_rd, half_of(code));
            idle(20);
        end

        // R4: BL=8, terminate 2 clocks after READ -> gap 6 instead of 8
        cfg_bl = 2'd1;
        idle(4);
        issue(RD, 4, 40, t_rd);
        step(1, NOP, 0, 0, g);
        step(1, BST, 0, 0, g);
        issue(WR, 4, 48, t_x);
        check("R4 shortened gap", t_x - t_rd, 6);
        idle(20);

        // R4: terminate right after READ -> gap 5, floor at cycle after BST
        issue(RD, 4, 60, t_rd);
        step(1, BST, 0, 0, g);
        issue(WR, 4, 64, t_x);
        check("R4 shortest gap", t_x - t_rd, 5);
        idle(20);

        // R5: BL=4, terminate after burst end -> gap stays 6
        cfg_bl = 2'd0;
        idle(4);
        issue(RD, 5, 80, t_rd);
        step(1, NOP, 0, 0, g);
        step(1, NOP, 0, 0, g);
        step(1, BST, 0, 0, g);
        issue(WR, 5, 84, t_x);
        check("R5 late terminate no effect", t_x - t_rd, 6);
        idle(20);

        // R5: terminate with no READ in flight
        step(1, BST, 0, 0, g);
        issue(WR, 6, 90, t_x);
        check("R5 idle terminate granted write", g, 1);

        // R9: WRITE then immediate READ
        issue(WR, 6, 92, t_x);
        issue(RD, 6, 96, t_rd);
        check("R9 READ after WRITE", t_rd - t_x, 1);
        idle(20);

        // R2: larger latencies, RL=6 WL=3 BL=8 skew=2 -> gap 10
        cfg_rl = 4'd6; cfg_wl = 4'd3; cfg_bl = 2'd1; cfg_skew = 3'd2;
        idle(4);
        issue(RD, 7, 200, t_rd);
        issue(WR, 7, 208, t_x);
        check("R2 gap with other latencies", t_x - t_rd, 10);
        idle(20);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule